// File: doc/BRIEF.md
# Single-Step Shift, Carry-Shift and Sign-Extend Unit

This unit is the shift slice of a 32-bit soft processor's execute stage. In one cycle it produces one of eight results from operand A. There are three one-position right shifts that push the outgoing bit 0 into the carry flag. There are two sign extensions, from a byte and from a halfword. There are three multi-position shifts, which leave the carry flag alone. All results come out of combinational logic. The only state is the carry flag, which the unit holds itself.

For the multi-position shifts, the amount comes from one of two places: a register operand or a 5-bit immediate field. In both cases only the low five bits count. The carry flag is exposed so that the rest of the core can read it. It changes on a rising clock edge, and only for an accepted one-position shift.

Top module: `shift_carry_unit`

## Requirements
- R1: After reset the carry flag `carry_o` is 0.
- R2: Operation code 0 (arithmetic step right) yields `{a[31], a[31:1]}` and presents `a[0]` on `carry_nxt_o`.
- R3: Operation code 1 (step right through carry) yields `{carry_o, a[31:1]}` and presents `a[0]` on `carry_nxt_o`.
- R4: Operation code 2 (logical step right) yields `{1'b0, a[31:1]}` and presents `a[0]` on `carry_nxt_o`.
- R5: `carry_we_o` is 1 exactly when `valid_i` is 1 and the operation code is 0, 1 or 2. On such a cycle `carry_o` takes the value of `carry_nxt_o` at the next rising edge.
- R6: Operation code 3 copies bit 7 of A into bits 31..8 and passes bits 7..0 through unchanged.
- R7: Operation code 4 copies bit 15 of A into bits 31..16 and passes bits 15..0 through unchanged.
- R8: Operation code 5 shifts A right by the amount and fills with zeros.
- R9: Operation code 6 shifts A right by the amount and fills with bit 31 of A.
- R10: Operation code 7 shifts A left by the amount and fills with zeros.
- R11: The amount is `amt_imm_i` when `use_imm_i` is 1. Otherwise it is bits 4..0 of `amt_reg_i`; bits 31..5 of `amt_reg_i` have no effect. An amount of 0 returns A unchanged and an amount of 31 is supported.
- R12: Operation codes 3 to 7, and any cycle with `valid_i` low, leave `carry_o` unchanged and drive `carry_we_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | The operation is issued this cycle |
| op_i | input | 3 | Operation code (0..7, see R2 to R10) |
| opa_i | input | 32 | Operand A |
| amt_reg_i | input | 32 | Register-sourced shift amount (only low 5 bits used) |
| amt_imm_i | input | 5 | Immediate shift amount |
| use_imm_i | input | 1 | 1 selects the immediate amount |
| res_o | output | 32 | Result |
| carry_nxt_o | output | 1 | Carry value to be written |
| carry_we_o | output | 1 | Carry write enable |
| carry_o | output | 1 | Current carry flag |

## Verification
A corrupted carry flag shows up in the very next step-right-through-carry result: bit 31 of `res_o` is wrong in the same cycle. It also shows up directly on `carry_o` one edge after the faulty write. A wrong stage in the multi-position shifter shows up in the same cycle as a bit-pattern error, but only for amounts whose binary form uses that stage. For that reason the stimulus covers every amount from 0 to 31, with both amount sources. The write enable is compared on every cycle, so a spurious or a missed carry update is seen at once.

// File: rtl/scu_pkg.sv
package scu_pkg;
  typedef enum logic [2:0] {
    OP_ASR1  = 3'd0,
    OP_RCR1  = 3'd1,
    OP_LSR1  = 3'd2,
    OP_EXTB  = 3'd3,
    OP_EXTH  = 3'd4,
    OP_BSRL  = 3'd5,
    OP_BSRA  = 3'd6,
    OP_BSLL  = 3'd7
  } scu_op_e;
endpackage

// File: rtl/scu_barrel.sv
module scu_barrel #(
  parameter int XLEN = 32,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data_i,
  input  logic [SHW-1:0]  amt_i,
  input  logic            left_i,
  input  logic            arith_i,
  output logic [XLEN-1:0] data_o
);
  logic [XLEN-1:0] rev_in, rev_out, core_out;
  logic [XLEN-1:0] stg [SHW+1];
  logic            fill;

  // left shift done as right shift on bit-reversed data
  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign rev_in[i]  = data_i[XLEN-1-i];
    assign rev_out[i] = core_out[XLEN-1-i];
  end

  assign fill   = arith_i & ~left_i & data_i[XLEN-1];
  assign stg[0] = left_i ? rev_in : data_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{SH{fill}}, stg[k][XLEN-1:SH]} : stg[k];
  end

  assign core_out = stg[SHW];
  assign data_o   = left_i ? rev_out : core_out;
endmodule

// File: rtl/scu_step.sv
module scu_step
  import scu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  scu_op_e         op_i,
  input  logic [XLEN-1:0] data_i,
  input  logic            carry_i,
  output logic [XLEN-1:0] data_o
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  always_comb begin
    unique case (op_i)
      OP_ASR1: data_o = {data_i[XLEN-1], data_i[XLEN-1:1]};
      OP_RCR1: data_o = {carry_i, data_i[XLEN-1:1]};
      OP_LSR1: data_o = {1'b0, data_i[XLEN-1:1]};
      OP_EXTB: data_o = {{(XLEN-BYTE_W){data_i[BYTE_W-1]}}, data_i[BYTE_W-1:0]};
      OP_EXTH: data_o = {{(XLEN-HALF_W){data_i[HALF_W-1]}}, data_i[HALF_W-1:0]};
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/scu_flag.sv
module scu_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/shift_carry_unit.sv
module shift_carry_unit
  import scu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] amt_reg_i,
  input  logic [SHW-1:0]  amt_imm_i,
  input  logic            use_imm_i,
  output logic [XLEN-1:0] res_o,
  output logic            carry_nxt_o,
  output logic            carry_we_o,
  output logic            carry_o
);
  scu_op_e         op;
  logic [SHW-1:0]  amt;
  logic [XLEN-1:0] barrel_res, step_res;
  logic            is_step, is_barrel;

  assign op        = scu_op_e'(op_i);
  assign amt       = use_imm_i ? amt_imm_i : amt_reg_i[SHW-1:0];
  assign is_step   = (op == OP_ASR1) || (op == OP_RCR1) || (op == OP_LSR1);
  assign is_barrel = (op == OP_BSRL) || (op == OP_BSRA) || (op == OP_BSLL);

  scu_barrel #(.XLEN(XLEN), .SHW(SHW)) u_barrel (
    .data_i  (opa_i),
    .amt_i   (amt),
    .left_i  (op == OP_BSLL),
    .arith_i (op == OP_BSRA),
    .data_o  (barrel_res)
  );

  scu_step #(.XLEN(XLEN)) u_step (
    .op_i    (op),
    .data_i  (opa_i),
    .carry_i (carry_o),
    .data_o  (step_res)
  );

  assign res_o       = is_barrel ? barrel_res : step_res;
  assign carry_nxt_o = opa_i[0];
  assign carry_we_o  = valid_i & is_step;

  scu_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (carry_we_o),
    .d_i    (carry_nxt_o),
    .q_o    (carry_o)
  );

  assert_carry_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_step) |=> (carry_o == $past(opa_i[0])));

  assert_carry_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && is_step) |=> $stable(carry_o));

  assert_rcr_msb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RCR1) |-> (res_o[XLEN-1] == carry_o));

  assert_zero_amt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_barrel && amt == '0) |-> (res_o == opa_i));

  assert_extb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_EXTB) |-> (res_o[XLEN-1:7] == '0 || res_o[XLEN-1:7] == '1));

  assert_exth_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_EXTH) |-> (res_o[XLEN-1:15] == '0 || res_o[XLEN-1:15] == '1));
endmodule

// File: tb/shift_carry_unit_test.sv
`timescale 1ns/1ps
module shift_carry_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid;
  logic [2:0]  op;
  logic [31:0] opa, amt_reg;
  logic [4:0]  amt_imm;
  logic        use_imm;
  logic [31:0] res;
  logic        c_nxt, c_we, c_q;

  int checks = 0;
  int errors = 0;
  logic model_c = 1'b0;

  always #2.5 clk = ~clk;

  shift_carry_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .opa_i(opa),
    .amt_reg_i(amt_reg), .amt_imm_i(amt_imm), .use_imm_i(use_imm),
    .res_o(res), .carry_nxt_o(c_nxt), .carry_we_o(c_we), .carry_o(c_q)
  );

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R2";  3'd1: return "R3";  3'd2: return "R4";
      3'd3: return "R6";  3'd4: return "R7";  3'd5: return "R8";
      3'd6: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one issue cycle: drive at negedge, compare combinational outputs, update model at posedge
  task automatic issue(input logic v, input logic [2:0] o, input logic [31:0] a,
                       input logic [31:0] ar, input logic [4:0] ai, input logic ui);
    logic [31:0] exp_r;
    logic [4:0]  n;
    logic        exp_we;
    @(negedge clk);
    valid = v; op = o; opa = a; amt_reg = ar; amt_imm = ai; use_imm = ui;
    n = ui ? ai : ar[4:0];
    case (o)
      3'd0: exp_r = 32'($signed(a) >>> 1);
      3'd1: exp_r = (a >> 1) | (32'(model_c) << 31);
      3'd2: exp_r = a >> 1;
      3'd3: exp_r = 32'($signed(a[7:0]));
      3'd4: exp_r = 32'($signed(a[15:0]));
      3'd5: exp_r = a >> n;
      3'd6: exp_r = 32'($signed(a) >>> n);
      default: exp_r = a << n;
    endcase
    exp_we = v && (o <= 3'd2);
    #1;
    check(req_of(o), res, exp_r);
    check("R5", {31'd0, c_we}, {31'd0, exp_we});
    if (o <= 3'd2) check(req_of(o), {31'd0, c_nxt}, {31'd0, a[0]});
    check(exp_we ? "R5" : "R12", {31'd0, c_q}, {31'd0, model_c});
    @(posedge clk);
    if (exp_we) model_c = a[0];
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    valid = 0; op = 0; opa = 0; amt_reg = 0; amt_imm = 0; use_imm = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {31'd0, c_q}, 32'd0);
    rst_n = 1'b1;
    // R3: carry 0 then 1 rotated into bit 31
    issue(1, 3'd1, 32'h0000_0003, 0, 0, 0);
    issue(1, 3'd1, 32'h8000_0002, 0, 0, 0);
    issue(1, 3'd0, 32'h8000_0001, 0, 0, 0); // R2 negative
    issue(1, 3'd2, 32'hFFFF_FFFE, 0, 0, 0); // R4
    // R12: valid low step op leaves carry
    issue(0, 3'd2, 32'h0000_0001, 0, 0, 0);
    issue(1, 3'd3, 32'h0000_0080, 0, 0, 0); // R6
    issue(1, 3'd3, 32'hFFFF_FF7F, 0, 0, 0);
    issue(1, 3'd4, 32'h0000_8000, 0, 0, 0); // R7
    issue(1, 3'd4, 32'hFFFF_7FFF, 0, 0, 0);
    // R11: upper register amount bits ignored (0x25 -> 5), imm path
    issue(1, 3'd5, 32'hF000_0000, 32'hFFFF_FFE5, 0, 0);
    issue(1, 3'd6, 32'h8000_0000, 0, 5'd31, 1);
    issue(1, 3'd7, 32'h0000_0001, 32'h0000_0020, 0, 0);
    for (int s = 0; s < 32; s++) begin
      issue(1, 3'd5 + 3'(s % 3), 32'hA5C3_0F81, 32'(s), 5'(31 - s), 1'(s[0]));
      issue(1, 3'd5 + 3'(s % 3), 32'h5A3C_F07E, 32'(s) | 32'h1234_5600, 5'(s), 1'(s[1]));
    end
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      issue(lfsr[3], lfsr[6:4], lfsr ^ 32'h3C3C_0F0F, {lfsr[15:0], lfsr[31:16]}, lfsr[12:8], lfsr[13]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule